// File: doc/BRIEF.md
# Half-Bridge Gate Guard and Fault Latch

This block sits between a serially loaded command register and the gate drivers of three half-bridges. Each half-bridge has a high-side and a low-side switch. The block turns the command enables into the six gate enables that are actually applied. It also holds the latched diagnostic status word that is shifted back to the host.

The block blocks and records any attempt to turn on both switches of one leg. It times the overcurrent comparator of each channel against a delay selected by a command bit. It applies supply lockout and thermal shutdown, and it latches the supply-fail, overcurrent, shoot-through and thermal-warning flags. Every latch stays set until the host sends a status reset while the underlying fault is gone. All timers count ticks of the system clock.

Each channel has its own overcurrent state machine with three states:
- `OC_IDLE` moves to `OC_TIMING` when the comparator flag is seen, and loads the delay at that moment.
- `OC_TIMING` returns to `OC_IDLE` if the flag drops. It moves to `OC_TRIPPED` when the flag has been seen on the loaded number of consecutive ticks.
- `OC_TRIPPED` returns to `OC_IDLE` only on a status reset with the flag low.

Top module: `hb_guard`

## Requirements
- R1: If `drv_cmd` asks for both switches of a channel at once (bit 2i is the low side and bit 2i+1 is the high side of channel i), both gate enables of that channel are low in the same cycle. `stat_word[12]` is high after the next clock edge.
- R2: `stat_word[12]` stays set until a clock edge with `clr_stb` high while no channel requests both switches. Until then, a channel that made the attempt keeps both gates off even when it is commanded to a single switch.
- R3: When a channel's `oc_flag` has been high on N consecutive clock edges, that channel's gates are off and `stat_word[13]` is set after the Nth edge and not before. N is `LONG_DLY` when `oc_fast` was 0 and `SHORT_DLY` when it was 1, sampled on the first of those edges. Other channels are unaffected.
- R4: Changing `oc_fast` while a channel is timing does not change that channel's delay. A drop of `oc_flag` before the delay expires restarts the count.
- R5: A channel tripped by overcurrent stays off, with `stat_word[13]` set, until a clock edge with `clr_stb` high and its `oc_flag` low.
- R6: `stat_word[15]` is set after any edge where `sup_ov` or `sup_uv` is high. It stays set after the supply recovers, and it clears only on a `clr_stb` edge with both flags low.
- R7: While `sup_ov` is high and `ovlo_sel` is 1, all six gates are off. When `sup_ov` falls, the commanded gates return with no new command. With `ovlo_sel` at 0, `sup_ov` has no effect on the gates.
- R8: While `sup_uv` is high, all six gates are off, whatever the command.
- R9: `stat_word[0]` is set after any edge with a `tw_flag` bit high. It stays set after the flag falls, until a `clr_stb` edge with all flags low. A thermal warning never turns a gate off.
- R10: A high `tsd_flag` bit turns all gates off at once and latches them off. They return only after a `clr_stb` edge taken while all `tsd_flag` bits are low.
- R11: `stat_word` bit 2i+1 equals `gate_lo[i]` and bit 2i+2 equals `gate_hi[i]`. Bits 7 to 11 and bit 14 read 0.
- R12: A status reset on an edge where the fault that set a latch is still present leaves that latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; timers count its rising edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| drv_cmd | input | 2*NUM_CH | Commanded switch enables, bit 2i low side and 2i+1 high side of channel i |
| ovlo_sel | input | 1 | 1: overvoltage forces all gates off |
| oc_fast | input | 1 | 1: short overcurrent delay, 0: long delay |
| clr_stb | input | 1 | Status reset strobe, one clock wide |
| oc_flag | input | NUM_CH | Per-channel overcurrent comparator |
| sup_ov | input | 1 | Supply overvoltage |
| sup_uv | input | 1 | Supply undervoltage |
| tw_flag | input | NUM_CH | Per-channel thermal warning |
| tsd_flag | input | NUM_CH | Per-channel thermal shutdown |
| gate_hi | output | NUM_CH | Applied high-side enables |
| gate_lo | output | NUM_CH | Applied low-side enables |
| stat_word | output | 16 | Latched diagnostic status word |

## Verification
The assertions assume that every fault flag and command input is synchronous to `clk` and holds steady between edges. They also assume that `clr_stb` is an ordinary level sampled at each edge rather than a pulse narrower than a clock. The stimulus changes inputs only one time unit after a rising edge and keeps `clr_stb` high for exactly one edge. It raises comparator flags only on a known edge, so that each consecutive-edge count the assertions and checks depend on starts at a defined tick.

// File: rtl/hb_guard_pkg.sv
package hb_guard_pkg;

    typedef enum logic [1:0] {
        OC_IDLE    = 2'd0,
        OC_TIMING  = 2'd1,
        OC_TRIPPED = 2'd2
    } oc_state_e;

    localparam int STAT_W   = 16;
    localparam int STAT_TW  = 0;
    localparam int STAT_STA = 12;
    localparam int STAT_OCD = 13;
    localparam int STAT_PSF = 15;

endpackage

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // a set in the same cycle as a clear wins, so a live fault re-latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= set_i | (q_o & ~clr_i);
    end

endmodule

// File: rtl/hb_oc_timer.sv
module hb_oc_timer
    import hb_guard_pkg::*;
#(
    parameter int LONG_DLY  = 200,
    parameter int SHORT_DLY = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_i,
    input  logic fast_i,
    input  logic clr_i,
    output logic trip_o
);

    localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
    localparam int CW      = $clog2(MAX_DLY + 1);

    oc_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic [CW-1:0]   lim_q, lim_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OC_IDLE;
            cnt_q   <= '0;
            lim_q   <= CW'(LONG_DLY);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        unique case (state_q)
            OC_IDLE: begin
                if (oc_i) begin
                    state_d = OC_TIMING;
                    cnt_d   = CW'(1);
                    lim_d   = fast_i ? CW'(SHORT_DLY) : CW'(LONG_DLY);
                end
            end
            OC_TIMING: begin
                if (!oc_i) begin
                    state_d = OC_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == lim_q - CW'(1)) begin
                    state_d = OC_TRIPPED;
                end else begin
                    cnt_d   = cnt_q + CW'(1);
                end
            end
            OC_TRIPPED: begin
                if (clr_i && !oc_i) begin
                    state_d = OC_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = OC_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        trip_o = (state_q == OC_TRIPPED);
    end

endmodule

// File: rtl/hb_guard.sv
module hb_guard
    import hb_guard_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int LONG_DLY  = 200,
    parameter int SHORT_DLY = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_CH-1:0]   drv_cmd,
    input  logic                  ovlo_sel,
    input  logic                  oc_fast,
    input  logic                  clr_stb,
    input  logic [NUM_CH-1:0]     oc_flag,
    input  logic                  sup_ov,
    input  logic                  sup_uv,
    input  logic [NUM_CH-1:0]     tw_flag,
    input  logic [NUM_CH-1:0]     tsd_flag,
    output logic [NUM_CH-1:0]     gate_hi,
    output logic [NUM_CH-1:0]     gate_lo,
    output logic [STAT_W-1:0]     stat_word
);

    localparam int MAP_W = 2 * NUM_CH;

    logic [NUM_CH-1:0] both_req;
    logic [NUM_CH-1:0] sta_q;
    logic [NUM_CH-1:0] trip;
    logic              psf_q, tw_q, tsd_q;
    logic              global_off;

    hb_fault_latch u_psf (
        .clk(clk), .rst_n(rst_n), .set_i(sup_ov | sup_uv),
        .clr_i(clr_stb), .q_o(psf_q));

    hb_fault_latch u_tw (
        .clk(clk), .rst_n(rst_n), .set_i(|tw_flag),
        .clr_i(clr_stb), .q_o(tw_q));

    hb_fault_latch u_tsd (
        .clk(clk), .rst_n(rst_n), .set_i(|tsd_flag),
        .clr_i(clr_stb), .q_o(tsd_q));

    assign global_off = sup_uv | (sup_ov & ovlo_sel) | tsd_q | (|tsd_flag);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic want_lo, want_hi, blocked;

        assign want_lo      = drv_cmd[2*ch];
        assign want_hi      = drv_cmd[2*ch+1];
        assign both_req[ch] = want_lo & want_hi;

        // any pending leg attempt keeps the clear from taking effect
        hb_fault_latch u_sta (
            .clk(clk), .rst_n(rst_n), .set_i(both_req[ch]),
            .clr_i(clr_stb & ~(|both_req)), .q_o(sta_q[ch]));

        hb_oc_timer #(
            .LONG_DLY (LONG_DLY),
            .SHORT_DLY(SHORT_DLY)
        ) u_oc (
            .clk(clk), .rst_n(rst_n), .oc_i(oc_flag[ch]),
            .fast_i(oc_fast), .clr_i(clr_stb), .trip_o(trip[ch]));

        assign blocked     = global_off | sta_q[ch] | trip[ch] | both_req[ch];
        assign gate_lo[ch] = want_lo & ~blocked;
        assign gate_hi[ch] = want_hi & ~blocked;
    end

    always_comb begin
        stat_word = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            stat_word[2*ch+1] = gate_lo[ch];
            stat_word[2*ch+2] = gate_hi[ch];
        end
        stat_word[STAT_TW]  = tw_q;
        stat_word[STAT_STA] = |sta_q;
        stat_word[STAT_OCD] = |trip;
        stat_word[STAT_PSF] = psf_q;
    end

    // every driver bit must land below the shoot-through bit
    if (MAP_W + 1 > STAT_STA) begin : g_bad_cfg
        initial $error("hb_guard: NUM_CH too large for status layout");
    end

endmodule

// File: rtl/hb_guard_chk.sv
module hb_guard_chk #(
    parameter int NUM_CH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NUM_CH-1:0] drv_cmd,
    input logic                clr_stb,
    input logic                sup_ov,
    input logic                sup_uv,
    input logic [NUM_CH-1:0]   tw_flag,
    input logic [NUM_CH-1:0]   tsd_flag,
    input logic [NUM_CH-1:0]   gate_hi,
    input logic [NUM_CH-1:0]   gate_lo,
    input logic [15:0]         stat_word
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[ch] && gate_lo[ch]));

        assert_attempt_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_cmd[2*ch] && drv_cmd[2*ch+1]) |=> stat_word[12]);
    end

    assert_attempt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[12] && !clr_stb) |=> stat_word[12]);

    assert_ocd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[13] && !clr_stb) |=> stat_word[13]);

    assert_psf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ov || sup_uv) |=> stat_word[15]);

    assert_uv_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sup_uv |-> (gate_hi == '0 && gate_lo == '0));

    assert_tw_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|tw_flag) |=> stat_word[0]);

    assert_tsd_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|tsd_flag) |-> (gate_hi == '0 && gate_lo == '0));

    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[11:7] == '0 && !stat_word[14]);

endmodule

bind hb_guard hb_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .drv_cmd(drv_cmd), .clr_stb(clr_stb),
    .sup_ov(sup_ov), .sup_uv(sup_uv), .tw_flag(tw_flag), .tsd_flag(tsd_flag),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .stat_word(stat_word));

// File: tb/test_hb_guard.sv
`timescale 1ns/1ps
module test_hb_guard;

    localparam int NCH   = 3;
    localparam int LONG  = 12;
    localparam int SHORT = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2*NCH-1:0] drv_cmd = '0;
    logic             ovlo_sel = 1'b0;
    logic             oc_fast = 1'b0;
    logic             clr_stb = 1'b0;
    logic [NCH-1:0]   oc_flag = '0;
    logic             sup_ov = 1'b0;
    logic             sup_uv = 1'b0;
    logic [NCH-1:0]   tw_flag = '0;
    logic [NCH-1:0]   tsd_flag = '0;
    logic [NCH-1:0]   gate_hi, gate_lo;
    logic [15:0]      stat_word;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hb_guard #(.NUM_CH(NCH), .LONG_DLY(LONG), .SHORT_DLY(SHORT)) i_hb_guard (
        .clk(clk), .rst_n(rst_n), .drv_cmd(drv_cmd), .ovlo_sel(ovlo_sel),
        .oc_fast(oc_fast), .clr_stb(clr_stb), .oc_flag(oc_flag),
        .sup_ov(sup_ov), .sup_uv(sup_uv), .tw_flag(tw_flag),
        .tsd_flag(tsd_flag), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .stat_word(stat_word));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_clear();
        clr_stb = 1'b1;
        tick();
        clr_stb = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [NCH-1:0] e_lo, e_hi;
        logic [5:0]     e_map;
        logic           any_both;

        ticks(2);
        check("R11 reset status", stat_word, 0);
        check("R11 reset gates", {gate_hi, gate_lo}, 0);
        rst_n = 1'b1;
        tick();

        // exhaustive command sweep: R1 and R11
        for (int c = 0; c < 64; c++) begin
            any_both = 1'b0;
            for (int i = 0; i < NCH; i++) begin
                e_lo[i] = c[2*i] & ~c[2*i+1];
                e_hi[i] = c[2*i+1] & ~c[2*i];
                e_map[2*i]   = e_lo[i];
                e_map[2*i+1] = e_hi[i];
                any_both |= c[2*i] & c[2*i+1];
            end
            drv_cmd = 6'(c);
            #1;
            check("R1 sweep gate_lo", gate_lo, e_lo);
            check("R1 sweep gate_hi", gate_hi, e_hi);
            check("R11 sweep status map", stat_word[6:1], e_map);
            tick();
            check("R1 sweep attempt flag", stat_word[12], any_both);
            drv_cmd = '0;
            do_clear();
        end

        // R2 / R12 shoot-through latch
        drv_cmd = 6'b001100;
        tick();
        drv_cmd = 6'b001000;
        #1;
        check("R2 blocked after attempt", gate_hi[1], 0);
        drv_cmd = 6'b001100;
        do_clear();
        check("R12 clear with live attempt", stat_word[12], 1);
        drv_cmd = 6'b001000;
        ticks(2);
        check("R2 still latched w/o clear", stat_word[12], 1);
        check("R2 still blocked", gate_hi[1], 0);
        do_clear();
        check("R2 cleared", stat_word[12], 0);
        check("R2 channel on after clear", gate_hi[1], 1);

        // R3 long delay
        drv_cmd = 6'b010010; // ch0 high, ch2 low
        oc_fast = 1'b0;
        oc_flag = 3'b001;
        ticks(LONG - 1);
        check("R3 long not yet tripped", {stat_word[13], gate_hi[0]}, 1);
        tick();
        check("R3 long tripped ocd", stat_word[13], 1);
        check("R3 long gate off", gate_hi[0], 0);
        check("R3 other channel unaffected", gate_lo[2], 1);
        // R5 latched until clear with flag low
        oc_flag = '0;
        ticks(3);
        check("R5 stays off w/o clear", gate_hi[0], 0);
        oc_flag = 3'b001;
        do_clear();
        check("R12 clear with live overcurrent", stat_word[13], 1);
        oc_flag = '0;
        do_clear();
        check("R5 ocd cleared", stat_word[13], 0);
        check("R5 gate back on", gate_hi[0], 1);

        // R3 short delay
        oc_fast = 1'b1;
        oc_flag = 3'b001;
        ticks(SHORT - 1);
        check("R3 short not yet", gate_hi[0], 1);
        tick();
        check("R3 short tripped", gate_hi[0], 0);
        oc_flag = '0;
        do_clear();

        // R4 frozen delay
        oc_fast = 1'b0;
        oc_flag = 3'b001;
        tick();
        oc_fast = 1'b1;
        ticks(LONG - 2);
        check("R4 selection frozen", gate_hi[0], 1);
        tick();
        check("R4 long delay kept", gate_hi[0], 0);
        oc_flag = '0;
        oc_fast = 1'b0;
        do_clear();
        // R4 restart on drop
        oc_flag = 3'b001;
        ticks(LONG - 1);
        oc_flag = '0;
        tick();
        oc_flag = 3'b001;
        ticks(LONG - 1);
        check("R4 restart after drop", {stat_word[13], gate_hi[0]}, 1);
        oc_flag = '0;
        tick();

        // R6 / R7 overvoltage
        ovlo_sel = 1'b1;
        sup_ov = 1'b1;
        #1;
        check("R7 ov forces off", {gate_hi, gate_lo}, 0);
        tick();
        check("R6 psf set on ov", stat_word[15], 1);
        sup_ov = 1'b0;
        #1;
        check("R7 outputs restored", {gate_hi, gate_lo}, 6'b001100);
        tick();
        check("R6 psf held", stat_word[15], 1);
        do_clear();
        check("R6 psf cleared", stat_word[15], 0);
        ovlo_sel = 1'b0;
        sup_ov = 1'b1;
        tick();
        check("R7 ov ignored when not selected", {gate_hi, gate_lo}, 6'b001100);
        sup_ov = 1'b0;
        tick();

        // R8 undervoltage
        sup_uv = 1'b1;
        #1;
        check("R8 uv holds off", {gate_hi, gate_lo}, 0);
        do_clear();
        check("R12 psf with live uv", stat_word[15], 1);
        sup_uv = 1'b0;
        #1;
        check("R8 back after uv", {gate_hi, gate_lo}, 6'b001100);
        do_clear();
        check("R6 psf cleared after uv", stat_word[15], 0);

        // R9 thermal warning
        tw_flag = 3'b010;
        tick();
        check("R9 warning set", stat_word[0], 1);
        check("R9 gates unaffected", {gate_hi, gate_lo}, 6'b001100);
        tw_flag = '0;
        ticks(2);
        check("R9 warning held", stat_word[0], 1);
        do_clear();
        check("R9 warning cleared", stat_word[0], 0);

        // R10 thermal shutdown
        tsd_flag = 3'b100;
        #1;
        check("R10 tsd immediate off", {gate_hi, gate_lo}, 0);
        tick();
        tsd_flag = '0;
        ticks(2);
        check("R10 tsd latched off", {gate_hi, gate_lo}, 0);
        do_clear();
        check("R10 on after clear", {gate_hi, gate_lo}, 6'b001100);

        summary();
    end

endmodule